// File: doc/BRIEF.md
# Keyboard and Pointer Host Controller Command Engine

This block sits between a host bus and two byte-wide device channels: one for a keyboard and one for an auxiliary pointing device. The host sees two byte registers, and a single address bit picks between them. Address 0 is the data port. Address 1 is the command port when written and the status port when read. The block decodes command bytes and holds a mode byte, a self-test flag and an output port byte. Each channel has a one-byte holding buffer. The block decides which buffer the host drains next and drives one level interrupt per channel.

Some commands take an operand. Such a command arms a pending write target, and the next data-port write is steered to that target instead of going to the keyboard. Bytes coming from a device enter its holding buffer through a ready/valid handshake. Bytes going to a device leave as a one-cycle strobe. Keyboard data always wins over auxiliary data, both for the read path and for the flags and interrupts.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After synchronous reset the mode byte is 0x03 and a status read returns 0x18. Both interrupts are low, both buffers are empty and `port_out` reads 0xCF.
- R2: Command 0x20 places the current mode byte in the keyboard buffer.
- R3: Each of the commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arms a write target. The next data write goes to the target the command names: 0x60 the mode byte, 0xD1 the output port, 0xD2 the keyboard buffer, 0xD3 the auxiliary buffer, 0xD4 a strobe on `aux_tx`. The target then clears.
- R4: A data write with no armed target is sent out as a one-cycle `kbd_tx_valid` strobe carrying the written byte.
- R5: Command 0xAA sets status bit 2 and queues 0x55. Commands 0xA9 and 0xAB each queue 0x00. Command 0xC0 queues 0x80. All of these go into the keyboard buffer.
- R6: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4. The keyboard interrupt follows the new bit 4 in the cycle after the command.
- R7: Status bit 0 is 1 when either buffer is full. Status bit 5 is 1 only when the auxiliary buffer is full and the keyboard buffer is empty.
- R8: `irq_kbd` is high exactly when the keyboard buffer is full, mode bit 0 is 1 and mode bit 4 is 0. `irq_aux` is high exactly when only the auxiliary buffer is full and mode bit 1 is 1. Both are registered levels.
- R9: A data read returns the auxiliary byte and empties that buffer only when the auxiliary buffer is the sole full one. Otherwise it returns the keyboard byte and empties the keyboard buffer.
- R10: An unrecognised command byte changes no state: the mode, status, buffers, target and both transmit strobes are all unaffected.
- R11: A mode write through 0x60 updates the interrupts and status flags in the cycle after the data write.
- R12: `port_out` shows the stored output port byte, with bit 4 replaced by status bit 0 and bit 5 replaced by status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 1 | 0 selects the data port, 1 selects the command/status port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; a data read empties the selected buffer |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, combinational from the address and the current state |
| kbd_rx_valid | input | 1 | Keyboard device offers a byte |
| kbd_rx_data | input | 8 | Keyboard device byte |
| kbd_rx_ready | output | 1 | Keyboard buffer can accept a byte |
| kbd_tx_valid | output | 1 | One-cycle strobe of a byte to the keyboard |
| kbd_tx_data | output | 8 | Byte to the keyboard |
| aux_rx_valid | input | 1 | Auxiliary device offers a byte |
| aux_rx_data | input | 8 | Auxiliary device byte |
| aux_rx_ready | output | 1 | Auxiliary buffer can accept a byte |
| aux_tx_valid | output | 1 | One-cycle strobe of a byte to the auxiliary device |
| aux_tx_data | output | 8 | Byte to the auxiliary device |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| port_out | output | 8 | Output port byte with the buffer flags merged in |

## Verification
The bench sweeps all 32 combinations of the two buffer states and the three mode bits that gate the interrupts. A design that let the auxiliary interrupt or flag through while keyboard data is waiting would fail there, and so would one that ignored the keyboard-disable bit. When both buffers are full, the bench reads twice and expects the keyboard byte first; swapped priority would return the pointer byte early. Each operand command is followed by a second, plain data write. A target that failed to clear would swallow that write instead of strobing the keyboard. Unknown commands and mode writes made while data waits check for stray state changes and for interrupts that lag a cycle behind.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int BYTE_W = 8;
    localparam int NCH    = 2;
    localparam int CH_KBD = 0;
    localparam int CH_AUX = 1;

    typedef logic [BYTE_W-1:0] byte_t;

    // command codes
    localparam byte_t OP_MODE_RD   = 8'h20;
    localparam byte_t OP_MODE_WR   = 8'h60;
    localparam byte_t OP_AUX_OFF   = 8'hA7;
    localparam byte_t OP_AUX_ON    = 8'hA8;
    localparam byte_t OP_AUX_TEST  = 8'hA9;
    localparam byte_t OP_SELF_TEST = 8'hAA;
    localparam byte_t OP_KBD_TEST  = 8'hAB;
    localparam byte_t OP_KBD_OFF   = 8'hAD;
    localparam byte_t OP_KBD_ON    = 8'hAE;
    localparam byte_t OP_IN_RD     = 8'hC0;
    localparam byte_t OP_PORT_WR   = 8'hD1;
    localparam byte_t OP_KBUF_WR   = 8'hD2;
    localparam byte_t OP_ABUF_WR   = 8'hD3;
    localparam byte_t OP_ADEV_WR   = 8'hD4;

    // mode bit positions
    localparam int MB_KIRQ_EN = 0;
    localparam int MB_AIRQ_EN = 1;
    localparam int MB_KBD_OFF = 4;
    localparam int MB_AUX_OFF = 5;

    // status bit positions
    localparam int SB_ANY_FULL = 0;
    localparam int SB_SELFOK   = 2;
    localparam int SB_LASTCMD  = 3;
    localparam int SB_UNLOCK   = 4;
    localparam int SB_AUX_FULL = 5;

    localparam byte_t MODE_INIT  = 8'h03;
    localparam byte_t OPORT_INIT = 8'hCF;

    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_MODE   = 3'd1,
        TGT_PORT   = 3'd2,
        TGT_KBUF   = 3'd3,
        TGT_ABUF   = 3'd4,
        TGT_AUXDEV = 3'd5
    } wr_target_e;

    typedef struct packed {
        logic       known;
        logic       queue;
        byte_t      qbyte;
        logic       arm;
        wr_target_e tgt;
        logic       mset;
        logic       mclr;
        byte_t      mmask;
        logic       selftest;
    } cmd_act_t;

    function automatic byte_t bit_mask(input int pos);
        byte_t m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  byte_t    cmd,
    input  byte_t    cur_mode,
    output cmd_act_t act
);
    always_comb begin
        act          = '0;
        act.tgt      = TGT_NONE;
        act.known    = 1'b1;
        unique case (cmd)
            OP_MODE_RD:   begin act.queue = 1'b1; act.qbyte = cur_mode; end
            OP_MODE_WR:   begin act.arm = 1'b1; act.tgt = TGT_MODE;   end
            OP_PORT_WR:   begin act.arm = 1'b1; act.tgt = TGT_PORT;   end
            OP_KBUF_WR:   begin act.arm = 1'b1; act.tgt = TGT_KBUF;   end
            OP_ABUF_WR:   begin act.arm = 1'b1; act.tgt = TGT_ABUF;   end
            OP_ADEV_WR:   begin act.arm = 1'b1; act.tgt = TGT_AUXDEV; end
            OP_AUX_OFF:   begin act.mset = 1'b1; act.mmask = bit_mask(MB_AUX_OFF); end
            OP_AUX_ON:    begin act.mclr = 1'b1; act.mmask = bit_mask(MB_AUX_OFF); end
            OP_KBD_OFF:   begin act.mset = 1'b1; act.mmask = bit_mask(MB_KBD_OFF); end
            OP_KBD_ON:    begin act.mclr = 1'b1; act.mmask = bit_mask(MB_KBD_OFF); end
            OP_SELF_TEST: begin act.selftest = 1'b1; act.queue = 1'b1; act.qbyte = 8'h55; end
            OP_AUX_TEST,
            OP_KBD_TEST:  begin act.queue = 1'b1; act.qbyte = 8'h00; end
            OP_IN_RD:     begin act.queue = 1'b1; act.qbyte = 8'h80; end
            default:      act.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/kbc_obuf.sv
module kbc_obuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inj_valid,
    input  logic [W-1:0] inj_data,
    input  logic         push_valid,
    input  logic [W-1:0] push_data,
    output logic         push_ready,
    input  logic         pop,
    output logic         full,
    output logic         full_nxt,
    output logic [W-1:0] data
);
    logic [W-1:0] data_nxt;

    assign push_ready = !full && !inj_valid;

    always_comb begin
        full_nxt = full;
        data_nxt = data;
        if (inj_valid) begin
            full_nxt = 1'b1;
            data_nxt = inj_data;
        end else if (push_valid && !full) begin
            full_nxt = 1'b1;
            data_nxt = push_data;
        end else if (pop) begin
            full_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            full <= full_nxt;
            data <= data_nxt;
        end
    end
endmodule

// File: rtl/kbc_arbiter.sv
module kbc_arbiter (
    input  logic kbd_full,
    input  logic aux_full,
    input  logic kirq_en,
    input  logic airq_en,
    input  logic kbd_off,
    output logic any_full,
    output logic aux_sel,
    output logic irq_k,
    output logic irq_a
);
    assign any_full = kbd_full || aux_full;
    assign aux_sel  = aux_full && !kbd_full;
    assign irq_k    = kbd_full && kirq_en && !kbd_off;
    assign irq_a    = aux_sel && airq_en;
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
    import kbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       kbd_rx_valid,
    input  logic [7:0] kbd_rx_data,
    output logic       kbd_rx_ready,
    output logic       kbd_tx_valid,
    output logic [7:0] kbd_tx_data,
    input  logic       aux_rx_valid,
    input  logic [7:0] aux_rx_data,
    output logic       aux_rx_ready,
    output logic       aux_tx_valid,
    output logic [7:0] aux_tx_data,
    output logic       irq_kbd,
    output logic       irq_aux,
    output logic [7:0] port_out
);
    logic wr_cmd, wr_dat, rd_dat;
    assign wr_cmd = host_wr && host_addr;
    assign wr_dat = host_wr && !host_addr;
    assign rd_dat = host_rd && !host_addr;

    byte_t      mode_q, mode_d, oport_q, oport_d;
    wr_target_e tgt_q, tgt_d;
    logic       self_q, self_d;
    cmd_act_t   act;
    logic       cmd_known;

    kbc_cmd_decode u_dec (
        .cmd      (host_wdata),
        .cur_mode (mode_q),
        .act      (act)
    );
    assign cmd_known = act.known;

    // per-channel holding buffers
    logic  [NCH-1:0]            inj_v, push_v, push_r, pop_v, full, full_n;
    logic  [NCH-1:0][BYTE_W-1:0] inj_d, push_d, buf_d;

    assign push_v = {aux_rx_valid, kbd_rx_valid};
    assign push_d = {aux_rx_data,  kbd_rx_data};
    assign kbd_rx_ready = push_r[CH_KBD];
    assign aux_rx_ready = push_r[CH_AUX];

    logic any_now, sel_aux_now, irqk_now, irqa_now;
    logic any_nx,  sel_aux_nx,  irqk_nx,  irqa_nx;

    always_comb begin
        inj_v = '0;
        inj_d = '0;
        if (wr_cmd && act.queue) begin
            inj_v[CH_KBD] = 1'b1;
            inj_d[CH_KBD] = act.qbyte;
        end
        if (wr_dat && tgt_q == TGT_KBUF) begin
            inj_v[CH_KBD] = 1'b1;
            inj_d[CH_KBD] = host_wdata;
        end
        if (wr_dat && tgt_q == TGT_ABUF) begin
            inj_v[CH_AUX] = 1'b1;
            inj_d[CH_AUX] = host_wdata;
        end
        pop_v         = '0;
        pop_v[CH_AUX] = rd_dat && sel_aux_now;
        pop_v[CH_KBD] = rd_dat && !sel_aux_now;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        kbc_obuf #(.W(BYTE_W)) u_buf (
            .clk        (clk),
            .rst        (rst),
            .inj_valid  (inj_v[c]),
            .inj_data   (inj_d[c]),
            .push_valid (push_v[c]),
            .push_data  (push_d[c]),
            .push_ready (push_r[c]),
            .pop        (pop_v[c]),
            .full       (full[c]),
            .full_nxt   (full_n[c]),
            .data       (buf_d[c])
        );
    end

    // control state next values
    always_comb begin
        mode_d  = mode_q;
        oport_d = oport_q;
        tgt_d   = tgt_q;
        self_d  = self_q;
        if (wr_cmd) begin
            if (act.arm)      tgt_d  = act.tgt;
            if (act.mset)     mode_d = mode_q | act.mmask;
            if (act.mclr)     mode_d = mode_q & ~act.mmask;
            if (act.selftest) self_d = 1'b1;
        end
        if (wr_dat) begin
            if (tgt_q == TGT_MODE) mode_d  = host_wdata;
            if (tgt_q == TGT_PORT) oport_d = host_wdata;
            tgt_d = TGT_NONE;
        end
    end

    kbc_arbiter u_arb_now (
        .kbd_full (full[CH_KBD]),
        .aux_full (full[CH_AUX]),
        .kirq_en  (mode_q[MB_KIRQ_EN]),
        .airq_en  (mode_q[MB_AIRQ_EN]),
        .kbd_off  (mode_q[MB_KBD_OFF]),
        .any_full (any_now),
        .aux_sel  (sel_aux_now),
        .irq_k    (irqk_now),
        .irq_a    (irqa_now)
    );

    kbc_arbiter u_arb_nxt (
        .kbd_full (full_n[CH_KBD]),
        .aux_full (full_n[CH_AUX]),
        .kirq_en  (mode_d[MB_KIRQ_EN]),
        .airq_en  (mode_d[MB_AIRQ_EN]),
        .kbd_off  (mode_d[MB_KBD_OFF]),
        .any_full (any_nx),
        .aux_sel  (sel_aux_nx),
        .irq_k    (irqk_nx),
        .irq_a    (irqa_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= MODE_INIT;
            oport_q      <= OPORT_INIT;
            tgt_q        <= TGT_NONE;
            self_q       <= 1'b0;
            irq_kbd      <= 1'b0;
            irq_aux      <= 1'b0;
            kbd_tx_valid <= 1'b0;
            kbd_tx_data  <= '0;
            aux_tx_valid <= 1'b0;
            aux_tx_data  <= '0;
        end else begin
            mode_q       <= mode_d;
            oport_q      <= oport_d;
            tgt_q        <= tgt_d;
            self_q       <= self_d;
            irq_kbd      <= irqk_nx;
            irq_aux      <= irqa_nx && any_nx;
            kbd_tx_valid <= wr_dat && tgt_q == TGT_NONE;
            aux_tx_valid <= wr_dat && tgt_q == TGT_AUXDEV;
            if (wr_dat && tgt_q == TGT_NONE)   kbd_tx_data <= host_wdata;
            if (wr_dat && tgt_q == TGT_AUXDEV) aux_tx_data <= host_wdata;
        end
    end

    byte_t status;
    always_comb begin
        status              = '0;
        status[SB_ANY_FULL] = any_now;
        status[SB_SELFOK]   = self_q;
        status[SB_LASTCMD]  = 1'b1;
        status[SB_UNLOCK]   = 1'b1;
        status[SB_AUX_FULL] = sel_aux_now;
    end

    assign host_rdata = host_addr ? status
                      : (sel_aux_now ? buf_d[CH_AUX] : buf_d[CH_KBD]);

    assign port_out = {oport_q[7:6], status[SB_AUX_FULL], status[SB_ANY_FULL], oport_q[3:0]};

    // irq levels on the current state feed nothing else; keep them visible to the checker
    logic irq_now_k, irq_now_a;
    assign irq_now_k = irqk_now;
    assign irq_now_a = irqa_now;
endmodule

// File: rtl/kbc_cmd_engine_chk.sv
module kbc_cmd_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_addr,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic       irq_kbd,
    input logic       irq_aux,
    input logic       irq_now_k,
    input logic       irq_now_a,
    input logic [7:0] port_out,
    input logic [2:0] tgt_q,
    input logic [7:0] mode_q,
    input logic       self_q,
    input logic       cmd_known
);
    p_reset_mode_r1: assert property (@(posedge clk)
        rst |=> (mode_q == 8'h03 && !irq_kbd && !irq_aux && tgt_q == 3'd0));

    p_target_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_addr) |=> (tgt_q == 3'd0));

    p_selftest_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr && host_wdata == 8'hAA) |=> self_q);

    p_kbd_off_gates_r6: assert property (@(posedge clk) disable iff (rst)
        mode_q[4] |-> !irq_kbd);

    p_aux_flag_sub_r7: assert property (@(posedge clk) disable iff (rst)
        port_out[5] |-> port_out[4]);

    p_kirq_prio_r8: assert property (@(posedge clk) disable iff (rst)
        irq_kbd |-> (port_out[4] && !port_out[5]));

    p_airq_alone_r8: assert property (@(posedge clk) disable iff (rst)
        irq_aux |-> port_out[5]);

    p_irq_registered_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_kbd == irq_now_k) && (irq_aux == irq_now_a));

    p_unknown_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr && !cmd_known) |=>
            ($stable(mode_q) && $stable(self_q) && $stable(tgt_q)));
endmodule

bind kbc_cmd_engine kbc_cmd_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .irq_kbd    (irq_kbd),
    .irq_aux    (irq_aux),
    .irq_now_k  (irq_now_k),
    .irq_now_a  (irq_now_a),
    .port_out   (port_out),
    .tgt_q      (tgt_q),
    .mode_q     (mode_q),
    .self_q     (self_q),
    .cmd_known  (cmd_known)
);

// File: tb/kbc_cmd_engine_tb.sv
module kbc_cmd_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       kbd_rx_valid = 1'b0, kbd_rx_ready, kbd_tx_valid;
    logic [7:0] kbd_rx_data = '0, kbd_tx_data;
    logic       aux_rx_valid = 1'b0, aux_rx_ready, aux_tx_valid;
    logic [7:0] aux_rx_data = '0, aux_tx_data;
    logic       irq_kbd, irq_aux;
    logic [7:0] port_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbc_cmd_engine u_dut (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .kbd_rx_valid(kbd_rx_valid), .kbd_rx_data(kbd_rx_data), .kbd_rx_ready(kbd_rx_ready),
        .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data),
        .aux_rx_valid(aux_rx_valid), .aux_rx_data(aux_rx_data), .aux_rx_ready(aux_rx_ready),
        .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data),
        .irq_kbd(irq_kbd), .irq_aux(irq_aux), .port_out(port_out)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0] sb_exp[$];
    string      sb_tag[$];
    event       rd_ev;

    task automatic chk(input string tag, input logic [7:0] actv, input logic [7:0] expv);
        total++;
        if (actv !== expv) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, actv, expv);
        end
    endtask

    // scoreboard monitor: compares each data-port read with the queued expectation
    always @(rd_ev) begin
        if (sb_exp.size() == 0) begin
            total++; bad++;
            $display("FAIL R9 actual=%02h expected=none (empty scoreboard)", host_rdata);
        end else begin
            chk(sb_tag.pop_front(), host_rdata, sb_exp.pop_front());
        end
    end

    task automatic hwrite(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wr = 1'b1; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
        #1;
    endtask

    task automatic expect_read(input string tag, input logic [7:0] e);
        sb_exp.push_back(e);
        sb_tag.push_back(tag);
        @(negedge clk);
        host_addr = 1'b0; host_rd = 1'b1;
        #1 -> rd_ev;
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0;
        #1;
    endtask

    task automatic get_status(output logic [7:0] v);
        @(negedge clk);
        host_addr = 1'b1;
        #1 v = host_rdata;
        host_addr = 1'b0;
    endtask

    task automatic dev_push(input bit aux, input logic [7:0] d);
        @(negedge clk);
        if (aux) begin aux_rx_valid = 1'b1; aux_rx_data = d; end
        else     begin kbd_rx_valid = 1'b1; kbd_rx_data = d; end
        @(posedge clk);
        @(negedge clk);
        aux_rx_valid = 1'b0; kbd_rx_valid = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] st;
        logic [7:0] base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        get_status(st);
        chk("R1 status", st, 8'h18);
        chk("R1 irq", {6'b0, irq_aux, irq_kbd}, 8'h00);
        chk("R1 port_out", port_out, 8'hCF);
        // R2 read mode
        hwrite(1'b1, 8'h20);
        expect_read("R2 mode after reset", 8'h03);

        // R8/R7/R9 sweep: every pending combination against every interrupt-gating mode
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] mb;
                logic kf, af, ek, ea;
                mb = {3'b000, m[2], 2'b00, m[1], m[0]};
                kf = p[0]; af = p[1];
                hwrite(1'b1, 8'h60);
                hwrite(1'b0, mb);
                if (af) dev_push(1'b1, 8'hA0 + 8'(p));
                if (kf) dev_push(1'b0, 8'hB0 + 8'(m));
                ek = kf && m[0] && !m[2];
                ea = af && !kf && m[1];
                chk("R8 irq_kbd", {7'b0, irq_kbd}, {7'b0, ek});
                chk("R8 irq_aux", {7'b0, irq_aux}, {7'b0, ea});
                get_status(st);
                chk("R7 status", st, 8'h18 | {2'b00, (af && !kf), 4'b0000, (af || kf)});
                if (kf) expect_read("R9 kbd first", 8'hB0 + 8'(m));
                if (af) expect_read("R9 aux byte", 8'hA0 + 8'(p));
            end
        end
        hwrite(1'b1, 8'h60);
        hwrite(1'b0, 8'h03);

        // R11 mode write with data waiting recomputes irq at once
        dev_push(1'b0, 8'h31);
        chk("R11 irq before", {7'b0, irq_kbd}, 8'h01);
        hwrite(1'b1, 8'h60);
        hwrite(1'b0, 8'h00);
        chk("R11 irq after mode write", {7'b0, irq_kbd}, 8'h00);
        hwrite(1'b1, 8'h60);
        hwrite(1'b0, 8'h03);
        chk("R11 irq restored", {7'b0, irq_kbd}, 8'h01);

        // R6 keyboard disable / enable
        hwrite(1'b1, 8'hAD);
        chk("R6 irq gated by AD", {7'b0, irq_kbd}, 8'h00);
        hwrite(1'b1, 8'hAE);
        chk("R6 irq back after AE", {7'b0, irq_kbd}, 8'h01);
        expect_read("R6 drain", 8'h31);
        hwrite(1'b1, 8'hAD);
        hwrite(1'b1, 8'hA7);
        hwrite(1'b1, 8'h20);
        expect_read("R6 mode after AD A7", 8'h33);
        hwrite(1'b1, 8'hA8);
        hwrite(1'b1, 8'hAE);
        hwrite(1'b1, 8'h20);
        expect_read("R6 mode after A8 AE", 8'h03);

        // R5 fixed responses
        get_status(st);
        chk("R5 selftest flag clear", st & 8'h04, 8'h00);
        hwrite(1'b1, 8'hAA);
        expect_read("R5 self test", 8'h55);
        get_status(st);
        chk("R5 selftest flag set", st, 8'h1C);
        hwrite(1'b1, 8'hA9);
        expect_read("R5 aux test", 8'h00);
        hwrite(1'b1, 8'hAB);
        expect_read("R5 kbd test", 8'h00);
        hwrite(1'b1, 8'hC0);
        expect_read("R5 input read", 8'h80);

        // R3 operand targets
        hwrite(1'b1, 8'hD2);
        hwrite(1'b0, 8'h77);
        get_status(st);
        chk("R3 kbuf status", st, 8'h1D);
        expect_read("R3 kbuf byte", 8'h77);
        hwrite(1'b1, 8'hD3);
        hwrite(1'b0, 8'h66);
        get_status(st);
        chk("R3 abuf status", st, 8'h3D);
        chk("R12 port flags", port_out, 8'hFF);
        chk("R3 abuf irq", {6'b0, irq_aux, irq_kbd}, 8'h02);
        expect_read("R3 abuf byte", 8'h66);
        hwrite(1'b1, 8'hD1);
        hwrite(1'b0, 8'h0D);
        chk("R12 port_out written", port_out, 8'h0D);
        dev_push(1'b0, 8'h12);
        chk("R12 port_out kbd flag", port_out, 8'h1D);
        expect_read("R12 drain", 8'h12);
        hwrite(1'b1, 8'hD4);
        hwrite(1'b0, 8'h11);
        chk("R3 aux strobe", {6'b0, kbd_tx_valid, aux_tx_valid}, 8'h01);
        chk("R3 aux byte", aux_tx_data, 8'h11);

        // R4 plain data write after the target cleared
        hwrite(1'b0, 8'h22);
        chk("R4 kbd strobe", {6'b0, kbd_tx_valid, aux_tx_valid}, 8'h02);
        chk("R4 kbd byte", kbd_tx_data, 8'h22);
        @(negedge clk); #1;
        chk("R4 strobe one cycle", {7'b0, kbd_tx_valid}, 8'h00);

        // R10 unknown command ignored
        get_status(base);
        hwrite(1'b1, 8'h5A);
        chk("R10 no strobe", {6'b0, kbd_tx_valid, aux_tx_valid}, 8'h00);
        get_status(st);
        chk("R10 status unchanged", st, base);
        hwrite(1'b1, 8'hD2);
        hwrite(1'b1, 8'h5B);
        hwrite(1'b0, 8'h44);
        chk("R10 target kept", {7'b0, kbd_tx_valid}, 8'h00);
        expect_read("R10 target survives unknown", 8'h44);
        hwrite(1'b1, 8'h20);
        expect_read("R10 mode unchanged", 8'h03);

        chk("R9 scoreboard drained", 8'(sb_exp.size()), 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule